// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Serial DAC Loader

This block is the digital front end of a four-channel voltage-output converter. A three-wire serial port carries 16-bit command words. Each word writes a data code into one of four input (holding) registers and sets that channel's power-down flag. A second register stage per channel, the output register, drives the converter code. A shared, level-sensitive, active-low load strobe moves all four holding values into the output registers together, so every channel can change on the same cycle.

The serial inputs, the load strobe and the chip select are brought into the system clock domain through two-flop synchronizers, and the serial clock is edge-detected there. A small state machine collects the frame. Its states are IDLE (chip select high, bit counter held at zero), SHIFT (chip select low, one bit taken per serial clock rising edge, counter saturating at 17) and COMMIT (a one-cycle write pulse). The transitions are: IDLE to SHIFT when chip select goes low; SHIFT to COMMIT when chip select returns high with exactly 16 bits counted; SHIFT to IDLE when chip select returns high with any other count; COMMIT to IDLE always. An external asynchronous reset and a power-on reset input clear every register and flag. Either one overrides all serial and strobe activity.

Word layout, MSB first: bits [15:14] channel select (00 = A, 01 = B, 10 = C, 11 = D), bit [13] power-down, bit [12] unused, bits [11:0] code. With a narrower `DATA_W` the code is taken from the top `DATA_W` bits of [11:0].

Top module: `qdac_loader`

## Requirements
- R1: While `rst_n` is low, every holding register, every output code and every power-down flag is zero, asynchronously to `clk`.
- R2: While `por_n` is low, the same all-zero state holds, exactly as for `rst_n`.
- R3: A frame of exactly 16 bits, sampled MSB first on serial clock rising edges while `cs_n` is low, is written when `cs_n` rises. Its code field [11:0] goes into the holding register picked by bits [15:14] (00 = A at `dac_codes[11:0]`, 01 = B at [23:12], 10 = C at [35:24], 11 = D at [47:36]). The other channels are left unchanged.
- R4: While `ldac_n` is high, the output codes do not change, even when holding registers are written.
- R5: While `ldac_n` is low, each output code follows its holding register every clock cycle. All four channels update together, and a write made while the strobe is low reaches the output without a new strobe.
- R6: Bit [13] of a committed frame is stored as the power-down flag `shdn[n]` of the addressed channel (1 = powered down). It takes effect at commit, whatever the state of `ldac_n`.
- R7: A frame of any bit count other than 16 (for example 15 or 17) changes no register and no flag.
- R8: Bit [12] of a frame has no effect on any output.
- R9: The bit counter restarts each time `cs_n` goes low, so a correct frame that follows a discarded one is written normally.
- R10: While either reset is low, neither serial frames nor a low `ldac_n` change any output, and the block leaves reset with every output at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External asynchronous clear, active low |
| por_n | input | 1 | Power-on clear from the supply monitor, active low |
| sclk | input | 1 | Serial clock, data sampled on its rising edge |
| cs_n | input | 1 | Serial chip select, active low; a frame ends when it rises |
| sdi | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Shared level-sensitive load strobe, active low |
| dac_codes | output | 4*DATA_W | Output register codes, channel A in the lowest bits |
| shdn | output | 4 | Per-channel power-down flags, bit 0 = channel A |

## Verification
On every cycle the assertions check these points. Output registers hold while the strobe is inactive and copy the previous holding value while it is active. A holding register changes only on its own write pulse. Every commit follows a count of exactly 16 bits, and the write pulse lasts one cycle. Everything is zero while either clear is asserted. The bench scenarios are needed for the end-to-end effects: the mapping from channel-select bits to output lanes, the unused bit being ignored, the rejection of 15- and 17-bit frames, the recovery after a rejected frame, transparency while the strobe is held low, and clears overriding traffic that arrives during reset.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int FRAME_W  = 16;
    localparam int N_CH     = 4;
    localparam int ADDR_MSB = 15;
    localparam int SD_BIT   = 13;
    localparam int RSV_BIT  = 12;
    localparam int CODE_MSB = 11;
    localparam int CODE_W   = CODE_MSB + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ser_state_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/qdac_serial_fsm.sv
module qdac_serial_fsm
    import qdac_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              sdi_s,
    output logic              wr_valid,
    output logic [1:0]        wr_addr,
    output logic              wr_sd,
    output logic [DATA_W-1:0] wr_code
);
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    ser_state_e         state_q, state_d;
    logic               sclk_prev_q;
    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sclk_rise;
    logic               unused_bits;

    assign sclk_rise = sclk_s & ~sclk_prev_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        wr_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n_s) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_n_s) begin
                    state_d = (cnt_q == CNT_W'(FRAME_W)) ? ST_COMMIT : ST_IDLE;
                end
            end
            ST_COMMIT: begin
                wr_valid = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            sclk_prev_q <= 1'b0;
            shift_q     <= '0;
            cnt_q       <= '0;
        end else begin
            sclk_prev_q <= sclk_s;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == ST_SHIFT && sclk_rise && !cs_n_s) begin
                shift_q <= {shift_q[FRAME_W-2:0], sdi_s};
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign wr_addr     = shift_q[ADDR_MSB -: 2];
    assign wr_sd       = shift_q[SD_BIT];
    assign wr_code     = shift_q[CODE_MSB -: DATA_W];
    assign unused_bits = ^shift_q[RSV_BIT:0];

    AST_COMMIT_LEN: assert property (@(posedge clk) disable iff (!clr_n)
        wr_valid |-> (cnt_q == CNT_W'(FRAME_W))); // R7
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!clr_n)
        wr_valid |=> !wr_valid); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!clr_n)
        cnt_q <= CNT_W'(CNT_MAX)); // R9
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              wr_en,
    input  logic              wr_sd,
    input  logic [DATA_W-1:0] wr_code,
    input  logic              ld_active,
    output logic [DATA_W-1:0] dac_code,
    output logic              shdn
);
    logic [DATA_W-1:0] in_q, dac_q;
    logic              sd_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            in_q <= '0;
            sd_q <= 1'b0;
        end else if (wr_en) begin
            in_q <= wr_code;
            sd_q <= wr_sd;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)         dac_q <= '0;
        else if (ld_active) dac_q <= in_q;
    end

    assign dac_code = dac_q;
    assign shdn     = sd_q;

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_active |=> $stable(dac_q)); // R4
    AST_DAC_FOLLOW: assert property (@(posedge clk) disable iff (!clr_n)
        ld_active |=> (dac_q == $past(in_q))); // R5
    AST_IN_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        !wr_en |=> ($stable(in_q) && $stable(sd_q))); // R3
endmodule

// File: rtl/qdac_loader.sv
module qdac_loader
    import qdac_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   por_n,
    input  logic                   sclk,
    input  logic                   cs_n,
    input  logic                   sdi,
    input  logic                   ldac_n,
    output logic [N_CH*DATA_W-1:0] dac_codes,
    output logic [N_CH-1:0]        shdn
);
    logic              clr_n;
    logic [3:0]        sync_q;
    logic              wr_valid, wr_sd;
    logic [1:0]        wr_addr;
    logic [DATA_W-1:0] wr_code;

    assign clr_n = rst_n & por_n;

    // bit order: [0] sclk, [1] cs_n, [2] sdi, [3] ldac_n
    qdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
        .clk     (clk),
        .clr_n   (clr_n),
        .d_async ({ldac_n, sdi, cs_n, sclk}),
        .q_sync  (sync_q)
    );

    qdac_serial_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .clr_n    (clr_n),
        .sclk_s   (sync_q[0]),
        .cs_n_s   (sync_q[1]),
        .sdi_s    (sync_q[2]),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_sd    (wr_sd),
        .wr_code  (wr_code)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        qdac_channel #(.DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .clr_n     (clr_n),
            .wr_en     (wr_valid && (wr_addr == 2'(ch))),
            .wr_sd     (wr_sd),
            .wr_code   (wr_code),
            .ld_active (~sync_q[3]),
            .dac_code  (dac_codes[ch*DATA_W +: DATA_W]),
            .shdn      (shdn[ch])
        );
    end

    AST_CLR_ZERO: assert property (@(posedge clk)
        !clr_n |-> (dac_codes == '0 && shdn == '0)); // R1
    AST_CLR_STAYS: assert property (@(posedge clk)
        (!rst_n || !por_n) |=> (!clr_n || (dac_codes == '0 && shdn == '0))); // R10
endmodule

// File: tb/qdac_loader_tb.sv
module qdac_loader_tb;
    localparam int DW = 12;

    logic clk = 1'b0;
    logic rst_n, por_n, sclk, cs_n, sdi, ldac_n;
    logic [4*DW-1:0] dac_codes;
    logic [3:0]      shdn;

    logic [DW-1:0] exp_in  [4];
    logic [DW-1:0] exp_dac [4];
    logic [3:0]    exp_sd;
    logic          ld_held;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    qdac_loader u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .sclk(sclk), .cs_n(cs_n),
        .sdi(sdi), .ldac_n(ldac_n), .dac_codes(dac_codes), .shdn(shdn)
    );

    function automatic logic [15:0] mk_frame(input logic [1:0] a, input logic sd,
                                             input logic rsv, input logic [11:0] c);
        return {a, sd, rsv, c};
    endfunction

    function automatic logic [4*DW-1:0] pack_dac();
        logic [4*DW-1:0] v;
        for (int i = 0; i < 4; i++) v[i*DW +: DW] = exp_dac[i];
        return v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin
            exp_in[i] = '0;
            exp_dac[i] = '0;
        end
        exp_sd = '0;
    endtask

    task automatic check_all(input string req);
        n_chk++;
        if (dac_codes !== pack_dac() || shdn !== exp_sd) begin
            n_bad++;
            $display("FAIL %s: dac=%h shdn=%b expected dac=%h shdn=%b",
                     req, dac_codes, shdn, pack_dac(), exp_sd);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, input logic live);
        cs_n = 1'b0;
        #50;
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            #40 sclk = 1'b1;
            #40 sclk = 1'b0;
        end
        #40 cs_n = 1'b1;
        #150;
        if (live && n == 16) begin
            exp_in[v[15:14]] = v[11:0];
            exp_sd[v[15:14]] = v[13];
            if (ld_held) for (int i = 0; i < 4; i++) exp_dac[i] = exp_in[i];
        end
    endtask

    task automatic pulse_ld();
        ldac_n = 1'b0;
        #100 ldac_n = 1'b1;
        #60;
        for (int i = 0; i < 4; i++) exp_dac[i] = exp_in[i];
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] f;
        int          len;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; por_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
        ldac_n = 1'b1; ld_held = 1'b0;
        model_clear();
        #100;
        check_all("R1 R2 reset state");
        por_n = 1'b1;
        #50;
        check_all("R1 rst_n alone holds zero");
        rst_n = 1'b1;
        #100;
        check_all("R10 zero after reset release");

        // R3 and R4: write every channel, outputs hold until strobe
        send_bits(32'(mk_frame(2'd0, 1'b0, 1'b0, 12'h123)), 16, 1'b1);
        send_bits(32'(mk_frame(2'd1, 1'b1, 1'b0, 12'h456)), 16, 1'b1);
        send_bits(32'(mk_frame(2'd2, 1'b0, 1'b0, 12'h789)), 16, 1'b1);
        send_bits(32'(mk_frame(2'd3, 1'b0, 1'b0, 12'hABC)), 16, 1'b1);
        check_all("R4 outputs held while strobe high, R6 flag at commit");
        pulse_ld();
        check_all("R3 R5 simultaneous load of all lanes");

        // R8: reserved bit set gives the same result as clear
        send_bits(32'(mk_frame(2'd2, 1'b0, 1'b1, 12'hFFF)), 16, 1'b1);
        pulse_ld();
        check_all("R8 reserved bit ignored");

        // R7: 15- and 17-bit frames discarded
        send_bits(32'(mk_frame(2'd0, 1'b1, 1'b0, 12'h555)) >> 1, 15, 1'b0);
        pulse_ld();
        check_all("R7 short frame discarded");
        send_bits({15'd0, 1'b1, mk_frame(2'd1, 1'b0, 1'b0, 12'h001)}, 17, 1'b0);
        pulse_ld();
        check_all("R7 long frame discarded");

        // R9: correct frame right after a discarded one
        send_bits(32'h0000_0ABC, 9, 1'b0);
        send_bits(32'(mk_frame(2'd0, 1'b1, 1'b0, 12'h0F0)), 16, 1'b1);
        pulse_ld();
        check_all("R9 counter restarts on cs_n fall");

        // R6: clear flag, strobe high
        send_bits(32'(mk_frame(2'd1, 1'b0, 1'b0, 12'h456)), 16, 1'b1);
        check_all("R6 flag cleared without strobe");

        // R5: strobe held low, writes pass straight through
        ldac_n = 1'b0; ld_held = 1'b1;
        #100;
        for (int i = 0; i < 4; i++) exp_dac[i] = exp_in[i];
        send_bits(32'(mk_frame(2'd3, 1'b1, 1'b0, 12'h321)), 16, 1'b1);
        check_all("R5 transparent while strobe low");
        send_bits(32'(mk_frame(2'd0, 1'b0, 1'b0, 12'hFFF)), 16, 1'b1);
        check_all("R5 transparent second write");
        ldac_n = 1'b1; ld_held = 1'b0;
        #60;

        // R10 and R1: traffic during external reset
        rst_n = 1'b0;
        model_clear();
        #20;
        check_all("R1 async clear by rst_n");
        ldac_n = 1'b0;
        send_bits(32'(mk_frame(2'd2, 1'b1, 1'b0, 12'h777)), 16, 1'b0);
        check_all("R10 frame and strobe ignored in reset");
        ldac_n = 1'b1;
        #60 rst_n = 1'b1;
        #100;
        check_all("R10 zero after rst_n release");

        // R2: power-on clear
        send_bits(32'(mk_frame(2'd1, 1'b1, 1'b0, 12'h999)), 16, 1'b1);
        pulse_ld();
        check_all("R3 write before power-on clear");
        por_n = 1'b0;
        model_clear();
        #20;
        check_all("R2 async clear by por_n");
        send_bits(32'(mk_frame(2'd1, 1'b1, 1'b0, 12'h444)), 16, 1'b0);
        check_all("R2 frame ignored during power-on clear");
        por_n = 1'b1;
        #100;

        // random mix
        for (int it = 0; it < 40; it++) begin
            f = 16'($urandom);
            case ($urandom % 6)
                0:       len = 15;
                1:       len = 17;
                default: len = 16;
            endcase
            send_bits(len == 17 ? {15'd0, 1'($urandom), f} :
                      (len == 15 ? 32'(f) >> 1 : 32'(f)), len, 1'b1);
            if ($urandom % 3 == 0) pulse_ld();
            check_all(len == 16 ? "R3 R6 R8 random frame" : "R7 random bad length");
        end
        finish_run();
    end
endmodule